// File: doc/BRIEF.md
# Memory Region Access Checker with Violation Capture

The block holds a small, parameterised set of address-range descriptors. Each one has a start and an end address, both kept at a coarse granularity set by a resolution shift. Each also has a two-bit access policy for every one of four domains, an enable and a lock. Every access presented on the check port carries an address, a two-bit domain and a read/write direction. The block compares the access against all enabled descriptors and returns a registered allow or deny answer one cycle later.

When an access is denied, every region the access fell into records the event: a flag, the offending domain and the offending address in shifted form. The first event sticks until software clears it. Clearing happens either by a read of the status word from a domain that has some right on that region, or by an explicit write. A lock freezes a descriptor until reset. Once locked, the descriptor can still be switched on, but it can never be switched off.

Top module: `mem_region_guard`

## Requirements
- R1: After the synchronous reset every descriptor is disabled, unlocked, with zero addresses and policies and a clear status; `resp_valid` and `cfg_rdata` are 0 and every access is allowed.
- R2: An access hits a region when the region is enabled and start <= (acc_addr >> SHIFT) <= end, both bounds inclusive; a disabled region never hits.
- R3: The control word keeps the policy of domain d in bits [2d+1:2d]. Code 0 gives no access, 1 write only, 2 read only and 3 read and write: bit 1 permits reads and bit 0 permits writes.
- R4: An access that hits no region is allowed; an access that hits several regions is allowed when at least one of them permits it.
- R5: `resp_valid` and `resp_allow` are registered and appear in the cycle after `acc_valid` is sampled.
- R6: A denied access sets, in each region it hit whose flag is clear, status bit 0 (flag), bits [2:1] (domain) and bits [SADDR_W+2:3] (shifted address); while the flag is set, later denials leave the status unchanged.
- R7: A status read returns the status as it was before the read; it clears the status only when the policy of `cfg_dom` in that region is nonzero, and otherwise leaves it intact.
- R8: A write to a status word with data bit 0 set clears that status; a write with bit 0 clear has no effect.
- R9: Control bit 31 is the lock. It stays set until reset, and while it is set, writes do not change the start, end, policy or lock fields of that region.
- R10: Control bit 30 is the enable; in a locked region a write may set it but cannot clear it.
- R11: A denial in the same cycle as a clear of the status is recorded, so the status then holds the new event.
- R12: Register index = region*4 + word, with word 0 start, 1 end, 2 control, 3 status; start and end sit in bits [SADDR_W-1:0], and read data appears in the cycle after `cfg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_idx | input | IDX_W | Register index (region*4 + word) |
| cfg_wdata | input | 32 | Register write data |
| cfg_dom | input | 2 | Domain issuing the register read |
| cfg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access to check is present |
| acc_addr | input | ADDR_W | Access byte address |
| acc_dom | input | 2 | Domain of the access |
| acc_wr | input | 1 | 1 for write, 0 for read |
| resp_valid | output | 1 | Check result valid |
| resp_allow | output | 1 | 1 when the access is permitted |

## Verification
Directed accesses probe each policy code against both directions: a wrong read/write bit decode shows up as a flipped answer. They also land one granule outside and exactly on both range bounds, which separates inclusive from exclusive compares. Overlapping regions with one permitting and one denying tell an any-permit rule apart from an all-permit rule. A disabled full-range region shows whether the enable gates matching. Status reads from a domain with no rights, then from one with rights, and a denial that coincides with a clear, tell apart which of the competing status updates wins. The random phase mixes descriptor writes (sometimes locking), reads from random domains and accesses over a narrow shifted-address window, so that hits, overlaps and repeated denials are frequent. All of these are checked against a bench model.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
  localparam int DOM_W  = 2;
  localparam int NDOM   = 4;
  localparam int POL_W  = DOM_W * NDOM;
  localparam int BIT_EN = 30;
  localparam int BIT_LK = 31;
  localparam int ST_FLAG    = 0;
  localparam int ST_DOM_LO  = 1;
  localparam int ST_ADDR_LO = 3;

  typedef enum logic [1:0] {
    REG_START = 2'd0,
    REG_END   = 2'd1,
    REG_CTRL  = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  // bit 1 grants reads, bit 0 grants writes
  function automatic logic pol_allows(input logic [1:0] p, input logic wr);
    return wr ? p[0] : p[1];
  endfunction
endpackage

// File: rtl/mrg_region.sv
module mrg_region
  import mrg_pkg::*;
#(
  parameter int SADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [31:0]        wdata,
  input  logic [DOM_W-1:0]   rd_dom,
  input  logic               acc_valid,
  input  logic [SADDR_W-1:0] acc_saddr,
  input  logic [DOM_W-1:0]   acc_dom,
  input  logic               acc_wr,
  input  logic               viol,
  output logic               hit,
  output logic               permit,
  output logic               flag,
  output logic [31:0]        rd_word
);
  logic [SADDR_W-1:0] start_q, end_q, vaddr_q;
  logic [POL_W-1:0]   pol_q;
  logic               en_q, lock_q, flag_q;
  logic [DOM_W-1:0]   vdom_q;
  logic               assoc, clr, capture;
  logic               unused_region;

  assign unused_region = ^wdata;

  assign hit     = en_q && (acc_saddr >= start_q) && (acc_saddr <= end_q);
  assign permit  = pol_allows(pol_q[{acc_dom, 1'b0} +: 2], acc_wr);
  assign assoc   = (pol_q[{rd_dom, 1'b0} +: 2] != 2'b00);
  assign clr     = (sel == REG_STAT) && ((rd_en && assoc) || (wr_en && wdata[0]));
  assign capture = acc_valid && viol && hit && (clr || !flag_q);
  assign flag    = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      end_q   <= '0;
      pol_q   <= '0;
      en_q    <= 1'b0;
      lock_q  <= 1'b0;
      flag_q  <= 1'b0;
      vdom_q  <= '0;
      vaddr_q <= '0;
    end else begin
      if (wr_en && !lock_q && sel == REG_START) start_q <= wdata[SADDR_W-1:0];
      if (wr_en && !lock_q && sel == REG_END)   end_q   <= wdata[SADDR_W-1:0];
      if (wr_en && sel == REG_CTRL) begin
        if (!lock_q) begin
          pol_q  <= wdata[POL_W-1:0];
          en_q   <= wdata[BIT_EN];
          lock_q <= wdata[BIT_LK];
        end else if (wdata[BIT_EN]) begin
          en_q <= 1'b1;
        end
      end
      // a new event beats a clear in the same cycle
      if (capture) begin
        flag_q  <= 1'b1;
        vdom_q  <= acc_dom;
        vaddr_q <= acc_saddr;
      end else if (clr) begin
        flag_q  <= 1'b0;
        vdom_q  <= '0;
        vaddr_q <= '0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (sel)
      REG_START: rd_word[SADDR_W-1:0] = start_q;
      REG_END:   rd_word[SADDR_W-1:0] = end_q;
      REG_CTRL: begin
        rd_word[POL_W-1:0] = pol_q;
        rd_word[BIT_EN]    = en_q;
        rd_word[BIT_LK]    = lock_q;
      end
      default: begin
        rd_word[ST_FLAG]                  = flag_q;
        rd_word[ST_DOM_LO +: DOM_W]       = vdom_q;
        rd_word[ST_ADDR_LO +: SADDR_W]    = vaddr_q;
      end
    endcase
  end

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  p_locked_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(start_q) && $stable(end_q) && $stable(pol_q)));
  p_enable_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (lock_q && en_q) |=> en_q);
  p_first_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> (flag_q && $stable(vaddr_q) && $stable(vdom_q)));
endmodule

// File: rtl/mrg_decide.sv
module mrg_decide #(
  parameter int N = 4
) (
  input  logic         acc_valid,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] permit,
  output logic         allow,
  output logic         viol
);
  assign allow = !(|hit) || (|(hit & permit));
  assign viol  = acc_valid && !allow;
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
  import mrg_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int SHIFT       = 12,
  localparam int SADDR_W    = ADDR_W - SHIFT,
  localparam int RSEL_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int IDX_W      = RSEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [31:0]        cfg_wdata,
  input  logic [DOM_W-1:0]   cfg_dom,
  output logic [31:0]        cfg_rdata,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [DOM_W-1:0]   acc_dom,
  input  logic               acc_wr,
  output logic               resp_valid,
  output logic               resp_allow
);
  logic [NUM_REGIONS-1:0] hit_vec, permit_vec, flag_vec;
  logic [31:0]            words [NUM_REGIONS];
  logic [SADDR_W-1:0]     saddr;
  logic [RSEL_W-1:0]      rsel;
  reg_sel_e               wsel;
  logic                   allow, viol;
  logic                   unused_top;

  assign saddr      = acc_addr[ADDR_W-1:SHIFT];
  assign unused_top = ^acc_addr[SHIFT-1:0];
  assign rsel       = cfg_idx[IDX_W-1:2];
  assign wsel       = reg_sel_e'(cfg_idx[1:0]);

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    mrg_region #(.SADDR_W(SADDR_W)) u_region (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (rsel == RSEL_W'(r))),
      .rd_en    (cfg_re && (rsel == RSEL_W'(r))),
      .sel      (wsel),
      .wdata    (cfg_wdata),
      .rd_dom   (cfg_dom),
      .acc_valid(acc_valid),
      .acc_saddr(saddr),
      .acc_dom  (acc_dom),
      .acc_wr   (acc_wr),
      .viol     (viol),
      .hit      (hit_vec[r]),
      .permit   (permit_vec[r]),
      .flag     (flag_vec[r]),
      .rd_word  (words[r])
    );
  end

  mrg_decide #(.N(NUM_REGIONS)) u_decide (
    .acc_valid(acc_valid),
    .hit      (hit_vec),
    .permit   (permit_vec),
    .allow    (allow),
    .viol     (viol)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      resp_valid <= acc_valid;
      resp_allow <= acc_valid && allow;
      if (cfg_re) cfg_rdata <= words[rsel];
    end
  end

  p_nomatch_allow_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !(|hit_vec)) |=> (resp_valid && resp_allow));
  p_deny_flagged_r6: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_allow) |-> (|flag_vec));
endmodule

// File: tb/tb_mem_region_guard.sv
module tb_mem_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int AW = 32;
  localparam int SH = 12;
  localparam int SW = AW - SH;
  localparam int IW = 4;

  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_re = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0] cfg_dom = '0;
  logic [31:0] cfg_rdata;
  logic acc_valid = 0, acc_wr = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_dom = '0;
  logic resp_valid, resp_allow;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_region_guard #(.NUM_REGIONS(NR), .ADDR_W(AW), .SHIFT(SH)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_dom(cfg_dom), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_dom(acc_dom), .acc_wr(acc_wr),
    .resp_valid(resp_valid), .resp_allow(resp_allow));

  // bench model
  logic [SW-1:0] m_start [NR];
  logic [SW-1:0] m_end   [NR];
  logic [SW-1:0] m_vaddr [NR];
  logic [7:0]    m_pol   [NR];
  logic [1:0]    m_vdom  [NR];
  logic          m_en [NR], m_lk [NR], m_flag [NR];

  task automatic m_reset();
    for (int r = 0; r < NR; r++) begin
      m_start[r] = '0; m_end[r] = '0; m_vaddr[r] = '0; m_pol[r] = '0;
      m_vdom[r] = '0; m_en[r] = 0; m_lk[r] = 0; m_flag[r] = 0;
    end
  endtask

  function automatic logic m_hit(int r, logic [SW-1:0] sa);
    return m_en[r] && sa >= m_start[r] && sa <= m_end[r];
  endfunction

  function automatic logic m_allow(logic [SW-1:0] sa, logic [1:0] d, logic wr);
    logic any = 0, ok = 0;
    for (int r = 0; r < NR; r++) begin
      logic [1:0] p;
      p = m_pol[r][2*d +: 2];
      if (m_hit(r, sa)) begin
        any = 1;
        if (wr ? p[0] : p[1]) ok = 1;
      end
    end
    return !any || ok;
  endfunction

  function automatic logic [31:0] m_word(int idx);
    int r = idx >> 2;
    logic [31:0] w = '0;
    case (idx & 3)
      0: w[SW-1:0] = m_start[r];
      1: w[SW-1:0] = m_end[r];
      2: begin w[7:0] = m_pol[r]; w[30] = m_en[r]; w[31] = m_lk[r]; end
      default: begin w[0] = m_flag[r]; w[2:1] = m_vdom[r]; w[SW+2:3] = m_vaddr[r]; end
    endcase
    return w;
  endfunction

  task automatic m_clear(int r);
    m_flag[r] = 0; m_vdom[r] = '0; m_vaddr[r] = '0;
  endtask

  task automatic m_write(int idx, logic [31:0] d);
    int r = idx >> 2;
    case (idx & 3)
      0: if (!m_lk[r]) m_start[r] = d[SW-1:0];
      1: if (!m_lk[r]) m_end[r] = d[SW-1:0];
      2: if (!m_lk[r]) begin m_pol[r] = d[7:0]; m_en[r] = d[30]; m_lk[r] = d[31]; end
         else if (d[30]) m_en[r] = 1;
      default: if (d[0]) m_clear(r);
    endcase
  endtask

  task automatic m_capture(logic [SW-1:0] sa, logic [1:0] d);
    for (int r = 0; r < NR; r++)
      if (m_hit(r, sa) && !m_flag[r]) begin
        m_flag[r] = 1; m_vdom[r] = d; m_vaddr[r] = sa;
      end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    m_reset();
  endtask

  task automatic do_write(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    m_write(idx, d);
  endtask

  task automatic do_read(int idx, logic [1:0] dom, string req);
    logic [31:0] exp = m_word(idx);
    @(negedge clk);
    cfg_re = 1; cfg_idx = IW'(idx); cfg_dom = dom;
    @(negedge clk);
    cfg_re = 0;
    chk(req, cfg_rdata, exp);
    if ((idx & 3) == 3 && m_pol[idx >> 2][2*dom +: 2] != 2'b00) m_clear(idx >> 2);
  endtask

  task automatic do_access(logic [SW-1:0] sa, logic [1:0] dom, logic wr, string req);
    logic exp = m_allow(sa, dom, wr);
    @(negedge clk);
    acc_valid = 1; acc_addr = {sa, SH'($urandom)}; acc_dom = dom; acc_wr = wr;
    @(negedge clk);
    acc_valid = 0;
    chk({req, " valid"}, 32'(resp_valid), 32'd1);
    chk({req, " allow"}, 32'(resp_allow), 32'(exp));
    if (!exp) m_capture(sa, dom);
  endtask

  // read of a status word and an access in the same cycle
  task automatic do_read_access(int idx, logic [1:0] rdom, logic [SW-1:0] sa,
                                logic [1:0] dom, logic wr, string req);
    logic exp_allow = m_allow(sa, dom, wr);
    logic [31:0] exp_rd = m_word(idx);
    @(negedge clk);
    cfg_re = 1; cfg_idx = IW'(idx); cfg_dom = rdom;
    acc_valid = 1; acc_addr = {sa, SH'(0)}; acc_dom = dom; acc_wr = wr;
    @(negedge clk);
    cfg_re = 0; acc_valid = 0;
    chk({req, " rdata"}, cfg_rdata, exp_rd);
    chk({req, " allow"}, 32'(resp_allow), 32'(exp_allow));
    if (m_pol[idx >> 2][2*rdom +: 2] != 2'b00) m_clear(idx >> 2);
    if (!exp_allow) m_capture(sa, dom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7719));
    m_reset();
    do_reset();

    // R1: reset state
    chk("R1 resp_valid", 32'(resp_valid), 32'd0);
    chk("R1 rdata", cfg_rdata, 32'd0);
    do_read(2, 2'd0, "R1 ctrl0");
    do_read(11, 2'd1, "R1 stat2");
    do_access(20'd3, 2'd3, 1'b1, "R1 open access");
    @(negedge clk);
    chk("R5 idle", 32'(resp_valid), 32'd0);

    // region 0: 4..7, dom0 RW, dom1 RO, dom2 WO, dom3 none (R3, R12)
    do_write(0, 32'd4);
    do_write(1, 32'd7);
    do_write(2, 32'h4000_001B);
    do_read(0, 2'd0, "R12 start0");
    do_read(2, 2'd0, "R12 ctrl0");
    do_access(20'd4, 2'd1, 1'b0, "R3 ro read");
    do_access(20'd4, 2'd1, 1'b1, "R3 ro write");
    do_read(3, 2'd3, "R6 first capture");
    do_access(20'd7, 2'd2, 1'b1, "R3 wo write");
    do_access(20'd7, 2'd2, 1'b0, "R3 wo read");
    do_read(3, 2'd3, "R6 first kept");
    do_access(20'd8, 2'd3, 1'b0, "R2 above end");
    do_access(20'd3, 2'd3, 1'b0, "R2 below start");
    do_access(20'd7, 2'd3, 1'b0, "R2 end inclusive");
    // R7: unassociated reader keeps, associated reader clears
    do_read(3, 2'd3, "R7 no-rights read");
    do_read(3, 2'd3, "R7 kept");
    do_read(3, 2'd0, "R7 rights read");
    do_read(3, 2'd3, "R7 cleared");

    // R8: explicit clear
    do_access(20'd5, 2'd3, 1'b1, "R8 setup");
    do_write(3, 32'hFFFF_FFFE);
    do_read(3, 2'd3, "R8 bit0 clear no effect");
    do_write(3, 32'd1);
    do_read(3, 2'd3, "R8 cleared");

    // R4 overlap: region 1 6..9 gives dom3 RW
    do_write(4, 32'd6);
    do_write(5, 32'd9);
    do_write(6, 32'h4000_00C0);
    do_access(20'd7, 2'd3, 1'b0, "R4 overlap any permits");
    do_access(20'd5, 2'd3, 1'b0, "R4 single deny");
    do_access(20'd9, 2'd0, 1'b1, "R4 only region1 denies");
    // R2 disabled region covering all
    do_write(8, 32'd0);
    do_write(9, 32'd15);
    do_write(10, 32'h0000_0000);
    do_access(20'd12, 2'd1, 1'b0, "R2 disabled no match");

    // R9/R10 lock region 2
    do_write(10, 32'h8000_0000);
    do_write(10, 32'h4000_00FF);
    do_read(10, 2'd0, "R10 enable set when locked");
    do_write(10, 32'h0000_0000);
    do_read(10, 2'd0, "R10 enable not cleared");
    do_write(8, 32'd5);
    do_read(8, 2'd0, "R9 start frozen");
    do_access(20'd12, 2'd1, 1'b0, "R9 locked denies");
    do_read(11, 2'd0, "R9 status");

    // R11: region0 holds dom3@5; clearing read plus new denial
    do_read(3, 2'd2, "R11 pre");
    do_read_access(3, 2'd0, 20'd4, 2'd1, 1'b1, "R11 same cycle");
    do_read(3, 2'd3, "R11 new event kept");

    // random phase from fresh reset
    do_reset();
    do_read(6, 2'd0, "R1 lock gone");
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      int r  = $urandom_range(0, NR-1);
      if (op < 5) begin
        do_access(SW'($urandom_range(0, 15)), 2'($urandom), 1'($urandom), "R2 R3 R4 R6 random access");
      end else if (op < 7) begin
        int w = $urandom_range(0, 3);
        logic [31:0] d;
        case (w)
          0, 1: d = 32'($urandom_range(0, 15));
          2: begin
            d = $urandom;
            d[31] = ($urandom_range(0, 15) == 0);
          end
          default: d = $urandom;
        endcase
        do_write(r*4 + w, d);
      end else begin
        do_read(r*4 + $urandom_range(0, 3), 2'($urandom), "R7 R9 R12 random read");
      end
    end
    for (int k = 0; k < NR*4; k++) do_read(k, 2'd0, "R12 final sweep");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule